// File: doc/BRIEF.md
# Machine Status Register with Legalized Fields

This block holds the machine status word of a processor hart and presents it in two views. The machine view shows every field. The supervisor view is a masked window onto the same flops. Software writes arrive with a select that picks the view. Each write is legalized before it commits: fields that are not writable keep their value, and a previous-privilege value naming a mode that is not built is dropped. The dirty-summary bit in the top position is recomputed from the floating-point and extension status fields each time the register updates.

Trap sequencing logic has its own load port. It sets the machine interrupt-enable, the saved interrupt-enable and the previous-privilege field directly. When the committed value changes any field that steers address translation, the block raises a one-cycle flush request for the translation caches.

Top module: `mstatus_csr`

## Requirements
- R1: After reset the machine view reads 0x00001800 (previous privilege = 3, machine mode, in bits 12:11; all else 0), the supervisor view reads 0 and the flush output is low.
- R2: A machine-view write updates only SIE (bit 1), MIE (3), SPIE (5), MPIE (7), SPP (8), MPP (12:11), FS (14:13), MPRV (17), SUM (18) and MXR (19). UIE (0), UPIE (4), XS (16:15) and every other bit below the top keep their value. The new value is visible in the cycle after the write edge.
- R3: A write or load carrying MPP = 2 leaves MPP unchanged, while the other fields in the same write still update.
- R4: When supervisor mode is not built, MPP = 1 is dropped. When user mode is not built, MPP = 0 is dropped. Value 3 is always accepted.
- R5: The top bit (SD, bit XLEN-1) reads 1 exactly when FS = 3 or XS = 3. It is recomputed on every update.
- R6: The supervisor view equals the machine view masked to UIE, SIE, UPIE, SPIE, SPP, FS, XS, SUM, MXR and SD. All other bits read 0.
- R7: A supervisor-view write can change only SIE, SPIE, SPP, FS, SUM and MXR. MIE, MPIE, MPP and MPRV keep their value.
- R8: flush_o is high for exactly the one cycle after an update whose committed value differs from the old value in MXR, MPP, MPRV or SUM. It stays low for any other update, including a rewrite of the same value or a dropped MPP.
- R9: A load (ld_en) sets MIE, MPIE and MPP (legalized as in R3/R4). The other fields keep their value. A write in the same cycle is discarded.
- R10: With neither wr_en nor ld_en the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_sup | input | 1 | 1 = write through supervisor view, 0 = machine view |
| wr_data | input | XLEN | Write value |
| ld_en | input | 1 | Trap-logic load strobe, takes priority over wr_en |
| ld_mie | input | 1 | Value loaded into MIE |
| ld_mpie | input | 1 | Value loaded into MPIE |
| ld_mpp | input | 2 | Value loaded into MPP (legalized) |
| mstatus_o | output | XLEN | Machine view |
| sstatus_o | output | XLEN | Supervisor view |
| flush_o | output | 1 | One-cycle translation flush request |

## Verification
A corrupted field in the stored word appears on mstatus_o, and on sstatus_o for shared fields, in the very next cycle after the faulty update. It persists until a later legal write overwrites it. A wrong legalization of MPP shows up both as a wrong MPP value and as a flush pulse that is present or missing in that same cycle. The bench runs three instances built with different mode sets and compares them each cycle, so a mode-dependent error is told apart from a shared one.

// File: rtl/mstatus_pkg.sv
package mstatus_pkg;

  // Field positions are fixed: trap, translation and FP logic decode them.
  localparam int unsigned UIE_B  = 0;
  localparam int unsigned SIE_B  = 1;
  localparam int unsigned MIE_B  = 3;
  localparam int unsigned UPIE_B = 4;
  localparam int unsigned SPIE_B = 5;
  localparam int unsigned MPIE_B = 7;
  localparam int unsigned SPP_B  = 8;
  localparam int unsigned MPP_LO = 11;
  localparam int unsigned FS_LO  = 13;
  localparam int unsigned XS_LO  = 15;
  localparam int unsigned MPRV_B = 17;
  localparam int unsigned SUM_B  = 18;
  localparam int unsigned MXR_B  = 19;

  // Low-word masks (fields below bit 20); the top bit is handled per width.
  localparam logic [31:0] MPP_M   = 32'h0000_1800;
  localparam logic [31:0] FS_M    = 32'h0000_6000;
  localparam logic [31:0] XS_M    = 32'h0001_8000;
  localparam logic [31:0] M_WR_M  = 32'h000E_79AA;
  localparam logic [31:0] S_VIS_M = 32'h000D_E133;
  localparam logic [31:0] XLAT_M  = 32'h000E_1800;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  function automatic logic mpp_ok(input logic [1:0] v, input bit has_s, input bit has_u);
    case (priv_e'(v))
      PRIV_M:  mpp_ok = 1'b1;
      PRIV_S:  mpp_ok = has_s;
      PRIV_U:  mpp_ok = has_u;
      default: mpp_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mstatus_legalize.sv
module mstatus_legalize
  import mstatus_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic [XLEN-1:0] cur,
  input  logic            wr_en,
  input  logic            wr_sup,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_en,
  input  logic            ld_mie,
  input  logic            ld_mpie,
  input  logic [1:0]      ld_mpp,
  output logic [XLEN-1:0] nxt,
  output logic            upd
);

  localparam int unsigned SD_B = XLEN - 1;
  localparam logic [XLEN-1:0] SD_M   = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] WR_M   = XLEN'(M_WR_M);
  localparam logic [XLEN-1:0] SV_M   = XLEN'(S_VIS_M) | SD_M;
  localparam logic [XLEN-1:0] MPP_XM = XLEN'(MPP_M);

  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] wr_val;
  logic [XLEN-1:0] ld_val;
  logic [XLEN-1:0] pre;
  logic [1:0]      fs_n;
  logic [1:0]      xs_n;

  // View merge: a supervisor write keeps machine-only bits from the old value.
  always_comb begin
    if (wr_sup) merged = (cur & ~SV_M) | (wr_data & SV_M);
    else        merged = wr_data;
  end

  always_comb begin
    wmask = WR_M;
    if (!mpp_ok(merged[MPP_LO +: 2], HAS_SMODE, HAS_UMODE)) wmask = wmask & ~MPP_XM;
    wr_val = (cur & ~wmask) | (merged & wmask);
  end

  always_comb begin
    ld_val          = cur;
    ld_val[MIE_B]   = ld_mie;
    ld_val[MPIE_B]  = ld_mpie;
    if (mpp_ok(ld_mpp, HAS_SMODE, HAS_UMODE)) ld_val[MPP_LO +: 2] = ld_mpp;
  end

  always_comb begin
    if (ld_en)      pre = ld_val;
    else if (wr_en) pre = wr_val;
    else            pre = cur;
    fs_n = pre[FS_LO +: 2];
    xs_n = pre[XS_LO +: 2];
    nxt  = pre;
    nxt[SD_B] = (fs_n == 2'b11) || (xs_n == 2'b11);
  end

  assign upd = wr_en | ld_en;

endmodule

// File: rtl/mstatus_flush_gen.sv
module mstatus_flush_gen
  import mstatus_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] nxt,
  output logic            flush_o
);

  localparam logic [XLEN-1:0] XL_M = XLEN'(XLAT_M);

  logic flush_d;
  logic flush_q;

  always_comb begin
    flush_d = upd && (((nxt ^ cur) & XL_M) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assign flush_o = flush_q;

  // R8: no pulse without an update in the previous cycle
  p_flush_needs_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !flush_q);

endmodule

// File: rtl/mstatus_csr.sv
module mstatus_csr
  import mstatus_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sup,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_en,
  input  logic            ld_mie,
  input  logic            ld_mpie,
  input  logic [1:0]      ld_mpp,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] sstatus_o,
  output logic            flush_o
);

  localparam logic [XLEN-1:0] SD_M    = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] SV_M    = XLEN'(S_VIS_M) | SD_M;
  localparam logic [XLEN-1:0] FIELD_M = XLEN'(M_WR_M | S_VIS_M) | SD_M;
  localparam logic [XLEN-1:0] XL_M    = XLEN'(XLAT_M);
  localparam logic [XLEN-1:0] RST_V   = XLEN'(MPP_M);

  logic [XLEN-1:0] st_q;
  logic [XLEN-1:0] st_d;
  logic            st_en;

  mstatus_legalize #(
    .XLEN      (XLEN),
    .HAS_SMODE (HAS_SMODE),
    .HAS_UMODE (HAS_UMODE)
  ) u_legal (
    .cur     (st_q),
    .wr_en   (wr_en),
    .wr_sup  (wr_sup),
    .wr_data (wr_data),
    .ld_en   (ld_en),
    .ld_mie  (ld_mie),
    .ld_mpie (ld_mpie),
    .ld_mpp  (ld_mpp),
    .nxt     (st_d),
    .upd     (st_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= RST_V;
    else if (st_en) st_q <= st_d;
  end

  mstatus_flush_gen #(
    .XLEN (XLEN)
  ) u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (st_en),
    .cur     (st_q),
    .nxt     (st_d),
    .flush_o (flush_o)
  );

  assign mstatus_o = st_q;
  assign sstatus_o = st_q & SV_M;

  // R2: bits outside every defined field never become set
  p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mstatus_o & ~FIELD_M) == '0);

  // R3: the reserved previous-privilege value is never stored
  p_mpp_no_rsv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mstatus_o[MPP_LO +: 2] != 2'b10);

  // R4: mode-dependent MPP legality
  generate
    if (!HAS_SMODE) begin : g_no_s
      p_mpp_no_s_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mstatus_o[MPP_LO +: 2] != 2'b01);
    end
    if (!HAS_UMODE) begin : g_no_u
      p_mpp_no_u_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mstatus_o[MPP_LO +: 2] != 2'b00);
    end
  endgenerate

  // R5: summary bit agrees with the dirty fields
  p_sd_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mstatus_o[XLEN-1] == ((mstatus_o[FS_LO +: 2] == 2'b11) || (mstatus_o[XS_LO +: 2] == 2'b11)));

  // R7: supervisor writes leave machine-only fields alone
  p_sup_keeps_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sup && !ld_en) |=> ($stable(mstatus_o[MIE_B]) && $stable(mstatus_o[MPIE_B])
      && $stable(mstatus_o[MPP_LO +: 2]) && $stable(mstatus_o[MPRV_B])));

  // R8: a pulse means translation fields changed, and its absence means they did not
  p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (((mstatus_o ^ $past(mstatus_o)) & XL_M) != '0));
  p_flush_missing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |-> (((mstatus_o ^ $past(mstatus_o)) & XL_M) == '0));

  // R10: idle cycles hold the register
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ld_en) |=> $stable(mstatus_o));

endmodule

// File: tb/mstatus_csr_tb.sv
`timescale 1ns/1ps
module mstatus_csr_tb;

  localparam int XLEN = 32;
  localparam logic [31:0] T_WR   = 32'h000E_79AA;
  localparam logic [31:0] T_SV   = 32'h800D_E133;
  localparam logic [31:0] T_XL   = 32'h000E_1800;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_sup, ld_en, ld_mie, ld_mpie;
  logic [XLEN-1:0] wr_data;
  logic [1:0] ld_mpp;

  logic [XLEN-1:0] m0, m1, m2, s0, s1, s2;
  logic f0, f1, f2;

  always #4 clk = ~clk;

  // full: S and U; u_dut_ms: S without U; u_dut_mu: U without S
  mstatus_csr #(.XLEN(XLEN), .HAS_SMODE(1'b1), .HAS_UMODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sup(wr_sup), .wr_data(wr_data),
    .ld_en(ld_en), .ld_mie(ld_mie), .ld_mpie(ld_mpie), .ld_mpp(ld_mpp),
    .mstatus_o(m0), .sstatus_o(s0), .flush_o(f0));
  mstatus_csr #(.XLEN(XLEN), .HAS_SMODE(1'b1), .HAS_UMODE(1'b0)) u_dut_ms (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sup(wr_sup), .wr_data(wr_data),
    .ld_en(ld_en), .ld_mie(ld_mie), .ld_mpie(ld_mpie), .ld_mpp(ld_mpp),
    .mstatus_o(m1), .sstatus_o(s1), .flush_o(f1));
  mstatus_csr #(.XLEN(XLEN), .HAS_SMODE(1'b0), .HAS_UMODE(1'b1)) u_dut_mu (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sup(wr_sup), .wr_data(wr_data),
    .ld_en(ld_en), .ld_mie(ld_mie), .ld_mpie(ld_mpie), .ld_mpp(ld_mpp),
    .mstatus_o(m2), .sstatus_o(s2), .flush_o(f2));

  typedef struct packed {
    logic [31:0] m;
    logic [31:0] s;
    logic        f;
  } obs_t;

  obs_t  q0[$], q1[$], q2[$];
  string tq[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [31:0] mdl [3];
  bit hs [3];
  bit hu [3];

  function automatic bit ok_mpp(logic [1:0] v, bit s, bit u);
    return (v == 2'd3) || (v == 2'd1 && s) || (v == 2'd0 && u);
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] old, bit we, bit sup, logic [31:0] d,
                                           bit le, bit mie, bit mpie, logic [1:0] mpp, bit s, bit u);
    logic [31:0] r;
    logic [31:0] mg;
    logic [31:0] wm;
    r = old;
    if (le) begin
      r[3] = mie;
      r[7] = mpie;
      if (ok_mpp(mpp, s, u)) r[12:11] = mpp;
    end else if (we) begin
      mg = sup ? ((old & ~T_SV) | (d & T_SV)) : d;
      wm = T_WR;
      if (!ok_mpp(mg[12:11], s, u)) wm[12:11] = 2'b00;
      r = (old & ~wm) | (mg & wm);
    end
    r[31] = (r[14:13] == 2'b11) || (r[16:15] == 2'b11);
    return r;
  endfunction

  task automatic step(string tag, bit we, bit sup, logic [31:0] d,
                      bit le, bit mie, bit mpie, logic [1:0] mpp);
    obs_t e [3];
    logic [31:0] n;
    @(negedge clk);
    wr_en = we; wr_sup = sup; wr_data = d;
    ld_en = le; ld_mie = mie; ld_mpie = mpie; ld_mpp = mpp;
    for (int i = 0; i < 3; i++) begin
      n = ref_next(mdl[i], we, sup, d, le, mie, mpie, mpp, hs[i], hu[i]);
      e[i].m = n;
      e[i].s = n & T_SV;
      e[i].f = (((n ^ mdl[i]) & T_XL) != 0);
      mdl[i] = n;
    end
    @(posedge clk);
    q0.push_back(e[0]); q1.push_back(e[1]); q2.push_back(e[2]); tq.push_back(tag);
  endtask

  task automatic cmp(string tag, string inst, obs_t act, obs_t exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual m=%h s=%h f=%b expected m=%h s=%h f=%b",
               tag, inst, act.m, act.s, act.f, exp.m, exp.s, exp.f);
    end
  endtask

  // Monitor: one item per cycle, popped at the falling edge after the update
  always @(negedge clk) begin
    if (tq.size() > 0) begin
      string t;
      t = tq.pop_front();
      cmp(t, "full", '{m: m0, s: s0, f: f0}, q0.pop_front());
      cmp(t, "no_u", '{m: m1, s: s1, f: f1}, q1.pop_front());
      cmp(t, "no_s", '{m: m2, s: s2, f: f2}, q2.pop_front());
    end
  end

  initial begin
    hs[0] = 1; hu[0] = 1;
    hs[1] = 1; hu[1] = 0;
    hs[2] = 0; hu[2] = 1;
    for (int i = 0; i < 3; i++) mdl[i] = 32'h0000_1800;
    rst_n = 1'b0;
    wr_en = 0; wr_sup = 0; wr_data = '0; ld_en = 0; ld_mie = 0; ld_mpie = 0; ld_mpp = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state",            0, 0, 32'h0,         0, 0, 0, 2'd0);
    step("R2 write all ones",         1, 0, 32'hFFFF_FFFF, 0, 0, 0, 2'd0);
    step("R10 R8 idle hold",          0, 0, 32'h0,         0, 0, 0, 2'd0);
    step("R3 reserved MPP dropped",   1, 0, 32'h0000_1000, 0, 0, 0, 2'd0);
    step("R4 MPP=S",                  1, 0, 32'h0000_0800, 0, 0, 0, 2'd0);
    step("R4 MPP=U FS=1",             1, 0, 32'h0000_2000, 0, 0, 0, 2'd0);
    step("R8 rewrite same value",     1, 0, 32'h0000_2000, 0, 0, 0, 2'd0);
    step("R5 FS=3 sets SD",           1, 0, 32'h0000_6000, 0, 0, 0, 2'd0);
    step("R5 FS=2 clears SD",         1, 0, 32'h0000_4000, 0, 0, 0, 2'd0);
    step("R7 R6 sup write ones",      1, 1, 32'hFFFF_FFFF, 0, 0, 0, 2'd0);
    step("R2 machine fields set",     1, 0, 32'h0002_1888, 0, 0, 0, 2'd0);
    step("R7 sup write zero",         1, 1, 32'h0000_0000, 0, 0, 0, 2'd0);
    step("R9 load beats write",       1, 0, 32'hFFFF_FFFF, 1, 1, 0, 2'd1);
    step("R9 R3 load reserved MPP",   0, 0, 32'h0,         1, 0, 1, 2'd2);
    step("R9 R4 load MPP=U",          0, 0, 32'h0,         1, 1, 1, 2'd0);
    step("R8 SUM toggles",            1, 1, 32'h0004_0000, 0, 0, 0, 2'd0);
    step("R10 idle after write",      0, 1, 32'hFFFF_FFFF, 0, 0, 0, 2'd0);
    step("R2 R5 FS=3 via sup",        1, 1, 32'h0000_6000, 0, 0, 0, 2'd0);
    step("R4 MPP=M always legal",     1, 0, 32'h0000_1800, 0, 0, 0, 2'd0);
    step("R8 idle no pulse",          0, 0, 32'h0,         0, 0, 0, 2'd0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule